// File: doc/BRIEF.md
# Nibble Accumulator Unit with Decimal Adjust

This unit keeps a 4-bit accumulator and a single carry bit and carries out the accumulator class of a small 4-bit processor: addition and subtraction through the carry, step up and step down, rotations through the carry, complements, carry transfers, a decimal adjust for packed BCD arithmetic and a conversion from a one-hot key line to a binary key number. An outside sequencer decodes each instruction into a 4-bit operation code, presents the second operand nibble (from a register or a memory cell), and pulses the execute enable for one clock. Fetching, the register file and memory are outside the unit.

The accumulator and carry change only on a rising clock edge with the execute enable high. A zero flag shows at all times whether the accumulator holds zero. There is no load operation; software places a value in the accumulator by clearing both registers and adding the value.

Top module: `nib_acc_unit`

## Requirements
- R1: With `rst` high at a rising edge the accumulator and carry become 0 whatever the other inputs are, and `zero_o` is then 1.
- R2: With `exec_en` low at a rising edge the accumulator and carry keep their values for any `op_code` and `operand`; code 0 (hold) also leaves both unchanged when enabled.
- R3: Code 1 (add) forms acc + operand + carry; the low four bits go to the accumulator and bit 4 to the carry.
- R4: Code 2 (subtract) forms acc + (operand XOR 15) + (carry XOR 1); low four bits to the accumulator, bit 4 to the carry, so carry 1 means no borrow occurred.
- R5: Code 3 (increment) adds 1 and code 4 (decrement) adds 15 to the accumulator; in both the carry receives bit 4 of the sum, so after decrement the carry is 0 only when the accumulator was 0.
- R6: Code 5 (rotate left) moves the carry into bit 0 and bit 3 into the carry; code 6 (rotate right) moves the carry into bit 3 and bit 0 into the carry.
- R7: Code 7 inverts all accumulator bits and leaves the carry; codes 9 (carry clear), 10 (carry invert) and 11 (carry set) change only the carry.
- R8: Code 8 clears both accumulator and carry.
- R9: Code 12 copies the carry into the accumulator (0 or 1) and clears the carry; code 13 loads 10 when the carry was 1 and 9 when it was 0, then clears the carry.
- R10: Code 14 (decimal adjust) adds 6 to the accumulator when the carry is 1 or the accumulator exceeds 9; the carry becomes 1 if that sum exceeds 15 and otherwise keeps its previous value.
- R11: Code 15 (key decode) maps accumulator 0,1,2,4,8 to 0,1,2,3,4 and every other value to 15; the carry is unchanged.
- R12: `zero_o` is 1 exactly when the accumulator holds 0, in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execute strobe; the operation takes effect at this edge |
| op_code | input | 4 | Decoded operation code (codes 0 to 15 as in the requirements) |
| operand | input | 4 | Second operand nibble for add and subtract |
| acc_q | output | 4 | Accumulator |
| carry_q | output | 1 | Carry / inverted borrow |
| zero_o | output | 1 | High while the accumulator is zero |

## Verification
The hardest corner to reach from the ports is the decimal adjust taken with the carry already set while the accumulator is 9 or less, where the adjusted value stays in range and the carry must stay at 1 rather than be recomputed. Because there is no load operation, the stimulus first clears both registers, adds the wanted value, then sets the carry with the carry-set code before issuing the adjust; the same clear-then-add sequence walks the key decoder through all sixteen accumulator values. Long stretches of random codes, operands and enable gaps are then compared cycle by cycle against a behavioural model.

// File: rtl/nib_acc_pkg.sv
package nib_acc_pkg;

  localparam int NIB_W     = 4;
  localparam int BCD_LIMIT = 9;
  localparam int BCD_FIX   = 6;
  localparam int OPC_W     = 4;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [NIB_W:0]   wide_t;

  typedef enum logic [OPC_W-1:0] {
    OP_HOLD = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUBB = 4'd2,
    OP_INCR = 4'd3,
    OP_DECR = 4'd4,
    OP_ROTL = 4'd5,
    OP_ROTR = 4'd6,
    OP_INVA = 4'd7,
    OP_ZERO = 4'd8,
    OP_CCLR = 4'd9,
    OP_CINV = 4'd10,
    OP_CSET = 4'd11,
    OP_CXFR = 4'd12,
    OP_CBCD = 4'd13,
    OP_DADJ = 4'd14,
    OP_KEYD = 4'd15
  } acc_op_e;

  // Nibble adder with carry in, result one bit wider.
  function automatic wide_t f_add(nib_t a, nib_t b, logic cin);
    return wide_t'(a) + wide_t'(b) + wide_t'(cin);
  endfunction

  // One-hot key line to key number; zero gives zero, anything else all ones.
  function automatic nib_t f_keydec(nib_t v);
    nib_t r;
    r = '1;
    if (v == '0) r = '0;
    for (int i = 0; i < NIB_W; i++) begin
      if (v == (nib_t'(1) << i)) r = nib_t'(i + 1);
    end
    return r;
  endfunction

  // Decimal adjust: returns {carry, value}.
  function automatic wide_t f_dadj(nib_t a, logic cin);
    logic  fix;
    wide_t t;
    fix = cin || (int'(a) > BCD_LIMIT);
    t   = wide_t'(a) + (fix ? wide_t'(BCD_FIX) : '0);
    return {t[NIB_W] | cin, t[NIB_W-1:0]};
  endfunction

endpackage

// File: rtl/nib_add_path.sv
module nib_add_path
  import nib_acc_pkg::*;
(
  input  acc_op_e op,
  input  nib_t    acc,
  input  logic    cin,
  input  nib_t    opnd,
  output nib_t    sum,
  output logic    cout
);
  nib_t  addend;
  logic  cfeed;
  wide_t res;

  always_comb begin
    unique case (op)
      OP_ADDC: begin addend = opnd;  cfeed = cin;  end
      OP_SUBB: begin addend = ~opnd; cfeed = ~cin; end
      OP_INCR: begin addend = '0;    cfeed = 1'b1; end
      OP_DECR: begin addend = '1;    cfeed = 1'b0; end
      default: begin addend = '0;    cfeed = 1'b0; end
    endcase
  end

  assign res  = f_add(acc, addend, cfeed);
  assign sum  = res[NIB_W-1:0];
  assign cout = res[NIB_W];
endmodule

// File: rtl/nib_rot_path.sv
module nib_rot_path
  import nib_acc_pkg::*;
(
  input  nib_t acc,
  input  logic cin,
  output nib_t rl_acc,
  output logic rl_c,
  output nib_t rr_acc,
  output logic rr_c
);
  assign {rl_c, rl_acc} = {acc, cin};
  assign {rr_acc, rr_c} = {cin, acc};
endmodule

// File: rtl/nib_dec_path.sv
module nib_dec_path
  import nib_acc_pkg::*;
(
  input  nib_t acc,
  input  logic cin,
  output nib_t adj_acc,
  output logic adj_c,
  output logic adj_fire,
  output nib_t key_acc,
  output nib_t tcs_acc
);
  wide_t adj;

  assign adj      = f_dadj(acc, cin);
  assign adj_acc  = adj[NIB_W-1:0];
  assign adj_c    = adj[NIB_W];
  assign adj_fire = cin || (int'(acc) > BCD_LIMIT);
  assign key_acc  = f_keydec(acc);
  assign tcs_acc  = cin ? nib_t'(BCD_LIMIT + 1) : nib_t'(BCD_LIMIT);
endmodule

// File: rtl/nib_acc_unit.sv
module nib_acc_unit
  import nib_acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             exec_en,
  input  logic [OPC_W-1:0] op_code,
  input  logic [NIB_W-1:0] operand,
  output logic [NIB_W-1:0] acc_q,
  output logic             carry_q,
  output logic             zero_o
);
  acc_op_e op;
  nib_t    add_sum, rl_acc, rr_acc, adj_acc, key_acc, tcs_acc;
  logic    add_cout, rl_c, rr_c, adj_c, daa_fire;
  nib_t    acc_d;
  logic    carry_d;

  assign op = acc_op_e'(op_code);

  nib_add_path u_add (
    .op(op), .acc(acc_q), .cin(carry_q), .opnd(operand),
    .sum(add_sum), .cout(add_cout)
  );

  nib_rot_path u_rot (
    .acc(acc_q), .cin(carry_q),
    .rl_acc(rl_acc), .rl_c(rl_c), .rr_acc(rr_acc), .rr_c(rr_c)
  );

  nib_dec_path u_dec (
    .acc(acc_q), .cin(carry_q),
    .adj_acc(adj_acc), .adj_c(adj_c), .adj_fire(daa_fire),
    .key_acc(key_acc), .tcs_acc(tcs_acc)
  );

  always_comb begin
    acc_d   = acc_q;
    carry_d = carry_q;
    unique case (op)
      OP_HOLD: ;
      OP_ADDC, OP_SUBB, OP_INCR, OP_DECR: begin
        acc_d   = add_sum;
        carry_d = add_cout;
      end
      OP_ROTL: begin acc_d = rl_acc;  carry_d = rl_c; end
      OP_ROTR: begin acc_d = rr_acc;  carry_d = rr_c; end
      OP_INVA: acc_d = ~acc_q;
      OP_ZERO: begin acc_d = '0; carry_d = 1'b0; end
      OP_CCLR: carry_d = 1'b0;
      OP_CINV: carry_d = ~carry_q;
      OP_CSET: carry_d = 1'b1;
      OP_CXFR: begin acc_d = nib_t'(carry_q); carry_d = 1'b0; end
      OP_CBCD: begin acc_d = tcs_acc;         carry_d = 1'b0; end
      OP_DADJ: begin acc_d = adj_acc;         carry_d = adj_c; end
      OP_KEYD: acc_d = key_acc;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (exec_en) begin
      acc_q   <= acc_d;
      carry_q <= carry_d;
    end
  end

  assign zero_o = (acc_q == '0);
endmodule

// File: rtl/nib_acc_chk.sv
module nib_acc_chk
  import nib_acc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             exec_en,
  input logic [OPC_W-1:0] op_code,
  input logic [NIB_W-1:0] acc_q,
  input logic             carry_q,
  input logic             zero_o,
  input logic             add_cout,
  input logic             daa_fire
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (acc_q == '0) && !carry_q);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable(acc_q) && $stable(carry_q));

  // R3
  add_carry_chk: assert property (@(posedge clk) disable iff (rst)
    exec_en && op_code == OP_ADDC |=> carry_q == $past(add_cout));

  // R6
  rotl_carry_chk: assert property (@(posedge clk) disable iff (rst)
    exec_en && op_code == OP_ROTL |=> carry_q == $past(acc_q[NIB_W-1]));

  // R7
  cset_only_chk: assert property (@(posedge clk) disable iff (rst)
    exec_en && op_code == OP_CSET |=> carry_q && $stable(acc_q));

  // R7
  cinv_only_chk: assert property (@(posedge clk) disable iff (rst)
    exec_en && op_code == OP_CINV |=> carry_q != $past(carry_q) && $stable(acc_q));

  // R8
  clear_both_chk: assert property (@(posedge clk) disable iff (rst)
    exec_en && op_code == OP_ZERO |=> zero_o && !carry_q);

  // R9
  cbcd_range_chk: assert property (@(posedge clk) disable iff (rst)
    exec_en && op_code == OP_CBCD |=> !carry_q &&
      (acc_q == nib_t'(BCD_LIMIT) || acc_q == nib_t'(BCD_LIMIT + 1)));

  // R10
  dadj_idle_chk: assert property (@(posedge clk) disable iff (rst)
    exec_en && op_code == OP_DADJ && !daa_fire |=> $stable(acc_q) && $stable(carry_q));

  // R11
  keyd_bad_chk: assert property (@(posedge clk) disable iff (rst)
    exec_en && op_code == OP_KEYD && !$onehot0(acc_q) |=> acc_q == '1);
endmodule

bind nib_acc_unit nib_acc_chk u_chk (.*);

// File: tb/nib_acc_unit_test.sv
`timescale 1ns/1ps
module nib_acc_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_en = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [3:0] operand = 4'd0;
  wire  [3:0] acc_q;
  wire        carry_q;
  wire        zero_o;

  int n_cmp = 0;
  int n_bad = 0;
  int ma = 0;
  int mc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nib_acc_unit uut (
    .clk(clk), .rst(rst), .exec_en(exec_en), .op_code(op_code),
    .operand(operand), .acc_q(acc_q), .carry_q(carry_q), .zero_o(zero_o)
  );

  task automatic model(input int op, input int b);
    int t;
    case (op)
      1:  begin t = ma + b + mc;             ma = t % 16; mc = t / 16; end
      2:  begin t = ma + (15 - b) + (1 - mc); ma = t % 16; mc = t / 16; end
      3:  begin t = ma + 1;                  ma = t % 16; mc = t / 16; end
      4:  begin t = ma + 15;                 ma = t % 16; mc = t / 16; end
      5:  begin t = ma * 2 + mc;             ma = t % 16; mc = t / 16; end
      6:  begin t = ma % 2; ma = ma / 2 + mc * 8; mc = t; end
      7:  ma = 15 - ma;
      8:  begin ma = 0; mc = 0; end
      9:  mc = 0;
      10: mc = 1 - mc;
      11: mc = 1;
      12: begin ma = mc; mc = 0; end
      13: begin ma = (mc == 1) ? 10 : 9; mc = 0; end
      14: begin
        t = ma;
        if (mc == 1 || ma > 9) t = ma + 6;
        if (t > 15) mc = 1;
        ma = t % 16;
      end
      15: begin
        if (ma == 0) ma = 0;
        else if (ma == 1) ma = 1;
        else if (ma == 2) ma = 2;
        else if (ma == 4) ma = 3;
        else if (ma == 8) ma = 4;
        else ma = 15;
      end
      default: ;
    endcase
  endtask

  task automatic compare(input string tag);
    int ez;
    ez = (ma == 0) ? 1 : 0;
    n_cmp++;
    if (int'(acc_q) != ma || int'(carry_q) != mc || int'(zero_o) != ez) begin
      n_bad++;
      $display("FAIL %s: acc=%0d carry=%0d zero=%0d expected acc=%0d carry=%0d zero=%0d",
               tag, acc_q, carry_q, zero_o, ma, mc, ez);
    end
  endtask

  // Called at a falling edge; drives, lets one rising edge pass, compares.
  task automatic step(input bit en, input int op, input int b, input string tag);
    exec_en = en;
    op_code = op[3:0];
    operand = b[3:0];
    if (en) model(op, b);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic preset(input int a, input int c);
    step(1, 8, 0, "R8");
    step(1, 1, a, "R3");
    if (c == 1) step(1, 11, 0, "R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    exec_en = 1'b1;
    op_code = 4'd11;
    operand = 4'd7;
    @(negedge clk);
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    exec_en = 1'b0;

    // R3 add corners
    preset(9, 1);
    step(1, 1, 9, "R3");
    step(1, 1, 15, "R3");
    // R4 subtract with and without borrow
    preset(3, 1);
    step(1, 2, 5, "R4");
    step(1, 2, 0, "R4");
    preset(7, 0);
    step(1, 2, 7, "R4");
    // R5 increment / decrement at wrap
    preset(15, 0);
    step(1, 3, 0, "R5");
    step(1, 4, 0, "R5");
    step(1, 4, 0, "R5");
    // R6 rotations
    preset(9, 1);
    step(1, 5, 0, "R6");
    step(1, 6, 0, "R6");
    step(1, 6, 0, "R6");
    // R7 complement and carry-only ops
    preset(5, 0);
    step(1, 7, 0, "R7");
    step(1, 10, 0, "R7");
    step(1, 9, 0, "R7");
    step(1, 11, 0, "R7");
    // R9 carry transfers
    step(1, 12, 0, "R9");
    step(1, 13, 0, "R9");
    step(1, 11, 0, "R7");
    step(1, 13, 0, "R9");
    // R10 decimal adjust corners
    preset(3, 1);
    step(1, 14, 0, "R10");
    preset(10, 0);
    step(1, 14, 0, "R10");
    preset(5, 0);
    step(1, 14, 0, "R10");
    preset(12, 1);
    step(1, 14, 0, "R10");
    // R11 every key value
    for (int v = 0; v < 16; v++) begin
      preset(v, v % 2);
      step(1, 15, 0, "R11");
    end
    // R2 disabled cycles with every code, and hold code enabled
    preset(6, 1);
    for (int k = 0; k < 16; k++) step(0, k, 15 - k, "R2");
    step(1, 0, 9, "R2");
    // R12 zero flag after a computed zero
    preset(1, 0);
    step(1, 4, 0, "R12");
    // R1 reset wins over an enabled operation
    preset(11, 1);
    exec_en = 1'b1; op_code = 4'd1; operand = 4'd3; rst = 1'b1;
    ma = 0; mc = 0;
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    // random stretch
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 6) != 0, $urandom % 16, $urandom % 16, "R3-random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule